// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies a run of bytes from a source address to a destination address through a simple request/acknowledge memory master port. Software sets up the source and destination addresses, the byte count and a control word through a small register port, then starts the channel. The start can come from a software start bit or from a hardware request line. Each beat is one read from the source followed by one write to the destination. The data travels right-justified on the 32-bit data bus.

The control word picks two things. The first is how requests map onto beats: cycle-steal gives one beat per request, and continuous mode runs beats back to back until the byte count is zero. The second is a link mode, which raises one-cycle request pulses toward two neighbouring channels after beats and/or after the final beat. A status word reports these bits:
- done
- busy
- a latched but unserved hardware request
- a source bus error
- a destination bus error
- a configuration error

A done interrupt can be enabled.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, all four registers read zero, and `irq`, `link1`, `link2` and `mem_req` are low.
- R2: The source size is control bits [7:6] and the destination size is bits [9:8]. Code 0 is 4 bytes, code 1 is 1 byte and code 2 is 2 bytes. A launch with code 3 on either side sets the configuration error (status bit 29) and done (bit 24), and makes no memory access.
- R3: A launch with a zero byte count, or with a count that is not a multiple of the larger of the two sizes, sets the configuration error and done and makes no memory access.
- R4: Each beat works as follows:
  - It reads the source with the source size.
  - It writes the destination with the destination size. The write data is the low min(source, destination) bytes of the read data, zero-extended.
  - The byte count (status bits [23:0]) then drops by the destination size.
- R5: The source address advances by the source size after each completed beat when bit 4 (source increment) or bit 3 (auto-align) is set. The destination address advances by the destination size when bit 5 (destination increment) or bit 3 is set. Otherwise each address stays fixed.
- R6: With bit 2 (cycle-steal) clear, one launch runs beats back to back until the count is zero. When the count reaches zero, done goes to 1 and busy (bit 25) goes to 0.
- R7: With cycle-steal set, each hardware request (`hw_req` high while bit 0, request enable, is set) runs exactly one beat. Busy stays high between beats until the count reaches zero.
- R8: Writing control bit 1 (start) launches the channel like one request. Bit 1 reads back 0 afterwards.
- R9: Link mode is bits [11:10]. The modes are:
  - Mode 0: no pulses.
  - Mode 1: `link1` pulses after every beat when cycle-steal is set, and `link2` pulses on the final beat.
  - Mode 2: `link1` pulses after every beat.
  - Mode 3: `link1` pulses on the final beat only.
- R10: `irq` is high exactly when done is set and control bit 12 (interrupt enable) is set.
- R11: A bus error on a read sets the source error (bit 28). A bus error on a write sets the destination error (bit 27). In both cases the channel stops: done is set and busy is cleared, and the addresses and the count keep their values from before the failing beat.
- R12: Writing status with bit 24 set clears done and all three error bits, and leaves the count unchanged. A status write with bit 24 clear loads the count.
- R13: In a hardware-launched continuous transfer, clearing request enable stops further beats with busy held and the count frozen. Setting request enable again resumes from the current addresses and count.
- R14: A hardware request that arrives while request enable is clear is held in the request-pending bit (bit 26). It is served, and the bit is cleared, once request enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 source address, 1 destination address, 2 status and count, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| hw_req | input | 1 | Hardware transfer request |
| irq | output | 1 | Done interrupt |
| link1 | output | 1 | One-cycle request pulse to the first linked channel |
| link2 | output | 1 | One-cycle request pulse to the second linked channel |
| mem_req | output | 1 | Memory access request, held until acknowledge or error |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Access size code, coded as in R2 |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access ended with a bus error |

## Verification
The assertions check three things on every cycle:
- A pending memory request holds its address until it is answered.
- A rejected configuration never reaches the bus, and busy never drops without done.
- A link-2 pulse only occurs in mode 1, a paused continuous channel stays idle, and an address without step enable never moves.

The bench scenarios show the data actually written, byte by byte, for mixed access sizes and fixed or advancing addresses. They also show the exact pulse counts of each link mode, pause and resume from a frozen count, the request-pending latch, and the address and count values left after a source or destination bus error.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int BUS_W = 32;

    localparam logic [1:0] OFF_SRC  = 2'd0;
    localparam logic [1:0] OFF_DST  = 2'd1;
    localparam logic [1:0] OFF_STAT = 2'd2;
    localparam logic [1:0] OFF_CTRL = 2'd3;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        LNK_NONE      = 2'd0,
        LNK_STEAL_END = 2'd1,
        LNK_EVERY     = 2'd2,
        LNK_END       = 2'd3
    } link_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic       irq_en;
        link_mode_e link_mode;
        xfer_size_e dst_size;
        xfer_size_e src_size;
        logic       dst_inc;
        logic       src_inc;
        logic       auto_align;
        logic       cycle_steal;
        logic       req_en;
    } ctrl_t;

    function automatic logic [2:0] size_bytes(input xfer_size_e s);
        case (s)
            SZ_WORD: size_bytes = 3'd4;
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] size_mask(input xfer_size_e s);
        case (s)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Control word layout: [0] request enable, [1] start, [2] cycle-steal,
    // [3] auto-align, [4] src inc, [5] dst inc, [7:6] src size,
    // [9:8] dst size, [11:10] link mode, [12] interrupt enable.
    function automatic ctrl_t ctrl_decode(input logic [12:0] w);
        ctrl_t c;
        c.req_en      = w[0];
        c.cycle_steal = w[2];
        c.auto_align  = w[3];
        c.src_inc     = w[4];
        c.dst_inc     = w[5];
        c.src_size    = xfer_size_e'(w[7:6]);
        c.dst_size    = xfer_size_e'(w[9:8]);
        c.link_mode   = link_mode_e'(w[11:10]);
        c.irq_en      = w[12];
        return c;
    endfunction

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output ctrl_t             ctrl_o,
    output logic              start_o,
    output logic [BUS_W-1:0]  rback_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  start;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i[BUS_W-1:13];

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (wr_i) begin
            s_d.ctrl  = ctrl_decode(wdata_i[12:0]);
            s_d.start = wdata_i[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o  = s_q.ctrl;
    assign start_o = s_q.start;

    always_comb begin
        rback_o        = '0;
        rback_o[0]     = s_q.ctrl.req_en;
        rback_o[1]     = s_q.start;
        rback_o[2]     = s_q.ctrl.cycle_steal;
        rback_o[3]     = s_q.ctrl.auto_align;
        rback_o[4]     = s_q.ctrl.src_inc;
        rback_o[5]     = s_q.ctrl.dst_inc;
        rback_o[7:6]   = s_q.ctrl.src_size;
        rback_o[9:8]   = s_q.ctrl.dst_size;
        rback_o[11:10] = s_q.ctrl.link_mode;
        rback_o[12]    = s_q.ctrl.irq_en;
    end

    // R8
    start_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && !wr_i |=> !start_o);

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              adv_i,
    input  logic              step_en_i,
    input  logic [2:0]        step_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i)                 addr_d = load_val_i;
        else if (adv_i && step_en_i) addr_d = addr_q + ADDR_W'(step_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R5
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !step_en_i |=> $stable(addr_o));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int COUNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl_i,
    input  logic               start_i,
    input  logic               hw_req_i,
    input  logic               count_load_i,
    input  logic [COUNT_W-1:0] count_val_i,
    input  logic               stat_clr_i,
    input  logic [ADDR_W-1:0]  src_addr_i,
    input  logic [ADDR_W-1:0]  dst_addr_i,
    output logic               adv_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [1:0]         mem_size_o,
    output logic [BUS_W-1:0]   mem_wdata_o,
    input  logic [BUS_W-1:0]   mem_rdata_i,
    input  logic               mem_ack_i,
    input  logic               mem_err_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               done_o,
    output logic               busy_o,
    output logic               pend_o,
    output logic               src_err_o,
    output logic               dst_err_o,
    output logic               cfg_err_o,
    output logic               link1_o,
    output logic               link2_o
);

    typedef struct packed {
        eng_state_e         st;
        logic [COUNT_W-1:0] count;
        logic [BUS_W-1:0]   data;
        logic               busy;
        logic               done;
        logic               pend;
        logic               src_err;
        logic               dst_err;
        logic               cfg_err;
        logic               sw_run;
        logic               link1;
        logic               link2;
    } eng_t;

    eng_t s_d, s_q;

    logic [2:0] src_b, dst_b, big_b;
    logic       cfg_bad, hw_go, go, last_beat;

    always_comb begin
        src_b     = size_bytes(ctrl_i.src_size);
        dst_b     = size_bytes(ctrl_i.dst_size);
        big_b     = (src_b > dst_b) ? src_b : dst_b;
        cfg_bad   = (ctrl_i.src_size == SZ_BAD) || (ctrl_i.dst_size == SZ_BAD) ||
                    (s_q.count == '0) || (|(s_q.count[2:0] & (big_b - 3'd1)));
        hw_go     = ctrl_i.req_en && s_q.pend;
        go        = start_i || hw_go;
        last_beat = (s_q.count == COUNT_W'(dst_b));
    end

    always_comb begin
        s_d         = s_q;
        s_d.link1   = 1'b0;
        s_d.link2   = 1'b0;
        adv_o       = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = src_addr_i;
        mem_size_o  = ctrl_i.src_size;
        mem_wdata_o = '0;

        if (hw_req_i && !(s_q.busy && !ctrl_i.cycle_steal)) s_d.pend = 1'b1;

        case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    if (!start_i) s_d.pend = 1'b0;
                    if (!s_q.busy) begin
                        if (cfg_bad) begin
                            s_d.cfg_err = 1'b1;
                            s_d.done    = 1'b1;
                        end else begin
                            s_d.busy    = 1'b1;
                            s_d.done    = 1'b0;
                            s_d.src_err = 1'b0;
                            s_d.dst_err = 1'b0;
                            s_d.cfg_err = 1'b0;
                            s_d.sw_run  = start_i;
                            s_d.st      = ST_READ;
                        end
                    end else begin
                        s_d.sw_run = s_q.sw_run | start_i;
                        s_d.st     = ST_READ;
                    end
                end else if (s_q.busy && !ctrl_i.cycle_steal &&
                             (ctrl_i.req_en || s_q.sw_run)) begin
                    s_d.st = ST_READ;
                end
            end
            ST_READ: begin
                mem_req_o = 1'b1;
                if (mem_err_i) begin
                    s_d.src_err = 1'b1;
                    s_d.done    = 1'b1;
                    s_d.busy    = 1'b0;
                    s_d.sw_run  = 1'b0;
                    s_d.st      = ST_IDLE;
                end else if (mem_ack_i) begin
                    s_d.data = mem_rdata_i & size_mask(ctrl_i.src_size);
                    s_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = dst_addr_i;
                mem_size_o  = ctrl_i.dst_size;
                mem_wdata_o = s_q.data & size_mask(ctrl_i.dst_size);
                if (mem_err_i) begin
                    s_d.dst_err = 1'b1;
                    s_d.done    = 1'b1;
                    s_d.busy    = 1'b0;
                    s_d.sw_run  = 1'b0;
                    s_d.st      = ST_IDLE;
                end else if (mem_ack_i) begin
                    adv_o     = 1'b1;
                    s_d.count = s_q.count - COUNT_W'(dst_b);
                    if (ctrl_i.link_mode == LNK_EVERY) s_d.link1 = 1'b1;
                    if (ctrl_i.link_mode == LNK_STEAL_END && ctrl_i.cycle_steal) s_d.link1 = 1'b1;
                    if (last_beat) begin
                        s_d.done   = 1'b1;
                        s_d.busy   = 1'b0;
                        s_d.sw_run = 1'b0;
                        s_d.st     = ST_IDLE;
                        if (ctrl_i.link_mode == LNK_STEAL_END) s_d.link2 = 1'b1;
                        if (ctrl_i.link_mode == LNK_END)       s_d.link1 = 1'b1;
                    end else if (!ctrl_i.cycle_steal && (ctrl_i.req_en || s_q.sw_run)) begin
                        s_d.st = ST_READ;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (count_load_i) s_d.count = count_val_i;
        if (stat_clr_i) begin
            s_d.done    = 1'b0;
            s_d.src_err = 1'b0;
            s_d.dst_err = 1'b0;
            s_d.cfg_err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o   = s_q.count;
    assign done_o    = s_q.done;
    assign busy_o    = s_q.busy;
    assign pend_o    = s_q.pend;
    assign src_err_o = s_q.src_err;
    assign dst_err_o = s_q.dst_err;
    assign cfg_err_o = s_q.cfg_err;
    assign link1_o   = s_q.link1;
    assign link2_o   = s_q.link2;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i && !mem_err_i && !count_load_i |=> mem_req_o && $stable(mem_addr_o));

    // R3
    cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st == ST_IDLE && !s_q.busy && go && cfg_bad && !stat_clr_i |=> cfg_err_o && !mem_req_o);

    // R6
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9
    link2_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link2_o |-> $past(ctrl_i.link_mode) == LNK_STEAL_END);

    // R11
    dst_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st == ST_WRITE && mem_err_i && !stat_clr_i |=> dst_err_o && !busy_o);

    // R13
    paused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st == ST_IDLE && s_q.busy && !ctrl_i.cycle_steal && !ctrl_i.req_en &&
        !s_q.sw_run && !start_i |=> s_q.st == ST_IDLE);

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int COUNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hw_req,
    output logic              irq,
    output logic              link1,
    output logic              link2,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err
);

    localparam int BIT_DONE = COUNT_W;
    localparam int BIT_BUSY = COUNT_W + 1;
    localparam int BIT_PEND = COUNT_W + 2;
    localparam int BIT_DERR = COUNT_W + 3;
    localparam int BIT_SERR = COUNT_W + 4;
    localparam int BIT_CERR = COUNT_W + 5;
    localparam int NSIDE    = 2;

    ctrl_t              ctrl;
    logic               start;
    logic [31:0]        ctrl_rb;
    logic               adv;
    logic [COUNT_W-1:0] count;
    logic               done, busy, pend, src_err, dst_err, cfg_err;
    logic               stat_wr, stat_clr, count_load;

    logic [ADDR_W-1:0]  side_addr [NSIDE];
    logic               side_load [NSIDE];
    logic               side_step_en [NSIDE];
    logic [2:0]         side_step [NSIDE];

    assign stat_wr    = reg_we && (reg_addr == OFF_STAT);
    assign stat_clr   = stat_wr && reg_wdata[BIT_DONE];
    assign count_load = stat_wr && !reg_wdata[BIT_DONE];

    dma_chan_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_we && (reg_addr == OFF_CTRL)),
        .wdata_i (reg_wdata),
        .ctrl_o  (ctrl),
        .start_o (start),
        .rback_o (ctrl_rb)
    );

    assign side_load[0]    = reg_we && (reg_addr == OFF_SRC);
    assign side_load[1]    = reg_we && (reg_addr == OFF_DST);
    assign side_step_en[0] = ctrl.src_inc | ctrl.auto_align;
    assign side_step_en[1] = ctrl.dst_inc | ctrl.auto_align;
    assign side_step[0]    = size_bytes(ctrl.src_size);
    assign side_step[1]    = size_bytes(ctrl.dst_size);

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_chan_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (side_load[g]),
            .load_val_i (reg_wdata[ADDR_W-1:0]),
            .adv_i      (adv),
            .step_en_i  (side_step_en[g]),
            .step_i     (side_step[g]),
            .addr_o     (side_addr[g])
        );
    end

    dma_chan_engine #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_i       (ctrl),
        .start_i      (start),
        .hw_req_i     (hw_req),
        .count_load_i (count_load),
        .count_val_i  (reg_wdata[COUNT_W-1:0]),
        .stat_clr_i   (stat_clr),
        .src_addr_i   (side_addr[0]),
        .dst_addr_i   (side_addr[1]),
        .adv_o        (adv),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_size_o   (mem_size),
        .mem_wdata_o  (mem_wdata),
        .mem_rdata_i  (mem_rdata),
        .mem_ack_i    (mem_ack),
        .mem_err_i    (mem_err),
        .count_o      (count),
        .done_o       (done),
        .busy_o       (busy),
        .pend_o       (pend),
        .src_err_o    (src_err),
        .dst_err_o    (dst_err),
        .cfg_err_o    (cfg_err),
        .link1_o      (link1),
        .link2_o      (link2)
    );

    assign irq = done & ctrl.irq_en;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_SRC: reg_rdata[ADDR_W-1:0] = side_addr[0];
            OFF_DST: reg_rdata[ADDR_W-1:0] = side_addr[1];
            OFF_STAT: begin
                reg_rdata[COUNT_W-1:0] = count;
                reg_rdata[BIT_DONE]    = done;
                reg_rdata[BIT_BUSY]    = busy;
                reg_rdata[BIT_PEND]    = pend;
                reg_rdata[BIT_DERR]    = dst_err;
                reg_rdata[BIT_SERR]    = src_err;
                reg_rdata[BIT_CERR]    = cfg_err;
            end
            default: reg_rdata = ctrl_rb;
        endcase
    end

    // R10
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done);

endmodule

// File: tb/test_dma_chan_top.sv
module test_dma_chan_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_req = 1'b0;
    logic        irq, link1, link2;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    always #4 clk = ~clk;

    dma_chan_top i_dma_chan_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
        .irq(irq), .link1(link1), .link2(link2), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // memory model: one-cycle response, byte array, injectable error address
    logic [7:0] mem [0:255];
    logic [7:0] exp_mem [0:255];
    logic       mem_init = 1'b0;
    logic       err_en = 1'b0;
    logic [7:0] err_addr = '0;
    int         acc_cnt = 0;
    int         l1_cnt = 0;
    int         l2_cnt = 0;

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 4 : (s == 2'd1) ? 1 : (s == 2'd2) ? 2 : 0;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else if (mem_req && !mem_ack && !mem_err) begin
            acc_cnt <= acc_cnt + 1;
            if (err_en && mem_addr[7:0] == err_addr) begin
                mem_err <= 1'b1;
            end else begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int b = 0; b < nbytes(mem_size); b++)
                        mem[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
                end else begin
                    logic [31:0] rd;
                    rd = '0;
                    for (int b = 0; b < nbytes(mem_size); b++)
                        rd[8*b +: 8] = mem[8'(mem_addr[7:0] + 8'(b))];
                    mem_rdata <= rd;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (link1) l1_cnt <= l1_cnt + 1;
        if (link2) l2_cnt <= l2_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); hw_req = 1'b1;
        @(negedge clk); hw_req = 1'b0;
    endtask

    task automatic init_mem();
        @(negedge clk); mem_init = 1'b1;
        @(negedge clk); mem_init = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd2, s);
            if (s[24]) break;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit ren, input bit st, input bit cs,
                                            input bit aa, input bit si, input bit di,
                                            input logic [1:0] ss, input logic [1:0] ds,
                                            input logic [1:0] lm, input bit ie);
        return {19'd0, ie, lm, ds, ss, di, si, aa, cs, st, ren};
    endfunction

    // bench model of one beat (R4, R5)
    task automatic model_run(input logic [7:0] s0, input logic [7:0] d0, input int cnt,
                             input logic [1:0] ss, input logic [1:0] ds, input bit si,
                             input bit di, input bit aa, output logic [7:0] sf,
                             output logic [7:0] df, output int beats);
        logic [7:0] sa, da;
        int sb, db, mn;
        logic [7:0] tmp [4];
        sb = nbytes(ss); db = nbytes(ds); mn = (sb < db) ? sb : db;
        sa = s0; da = d0; beats = 0;
        for (int k = 0; k < cnt / db; k++) begin
            for (int b = 0; b < 4; b++) tmp[b] = (b < mn) ? exp_mem[8'(sa + 8'(b))] : 8'h00;
            for (int b = 0; b < db; b++) exp_mem[8'(da + 8'(b))] = tmp[b];
            if (si || aa) sa = sa + 8'(sb);
            if (di || aa) da = da + 8'(db);
            beats++;
        end
        sf = sa; df = da;
    endtask

    typedef struct packed {
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] cnt;
        logic [1:0] ss;
        logic [1:0] ds;
        logic       si;
        logic       di;
        logic       aa;
        logic [7:0] exp_beats;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h80, 8'd16, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 8'd4},
        '{8'h10, 8'h90, 8'd8,  2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 8'd8},
        '{8'h20, 8'hA0, 8'd8,  2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 8'd4},
        '{8'h30, 8'hB0, 8'd8,  2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 8'd4},
        '{8'h04, 8'hC0, 8'd8,  2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 8'd2},
        '{8'h08, 8'hD0, 8'd4,  2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd4}
    };

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [7:0]  sf, df;
        int beats, a0, l10, l20;

        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            chk("R1 reg reset", v, 32'h0);
        end
        chk("R1 outputs idle", {28'd0, irq, link1, link2, mem_req}, 32'h0);

        // vector table: continuous software-started runs (R4 R5 R6 R8 R9)
        for (int n = 0; n < NVEC; n++) begin
            init_mem();
            wr(2'd2, 32'h0100_0000);
            wr(2'd0, {24'd0, VECS[n].src});
            wr(2'd1, {24'd0, VECS[n].dst});
            wr(2'd2, {24'd0, VECS[n].cnt});
            a0 = acc_cnt; l10 = l1_cnt; l20 = l2_cnt;
            model_run(VECS[n].src, VECS[n].dst, int'(VECS[n].cnt), VECS[n].ss, VECS[n].ds,
                      VECS[n].si, VECS[n].di, VECS[n].aa, sf, df, beats);
            wr(2'd3, mk_ctrl(0, 1, 0, VECS[n].aa, VECS[n].si, VECS[n].di,
                             VECS[n].ss, VECS[n].ds, 2'd0, 0));
            wait_done();
            idle(2);
            rd(2'd2, v);
            chk("R6 status done, count zero", v, 32'h0100_0000);
            rd(2'd0, v);
            chk("R5 final source address", v, {24'd0, sf});
            rd(2'd1, v);
            chk("R5 final destination address", v, {24'd0, df});
            chk("R4 beat count", 32'(beats), 32'(VECS[n].exp_beats));
            chk("R4 access count", 32'(acc_cnt - a0), 32'(2 * beats));
            chk("R9 mode 0 no link pulses", 32'((l1_cnt - l10) + (l2_cnt - l20)), 32'd0);
            for (int i = 0; i < 256; i++)
                if (mem[i] !== exp_mem[i]) chk("R4 memory image", {24'd0, mem[i]}, {24'd0, exp_mem[i]});
            rd(2'd3, v);
            chk("R8 start reads zero", {31'd0, v[1]}, 32'd0);
        end

        // R2 size code 3
        wr(2'd2, 32'h0100_0000);
        wr(2'd2, 32'd8);
        a0 = acc_cnt;
        wr(2'd3, mk_ctrl(0, 1, 0, 0, 1, 1, 2'd3, 2'd1, 2'd0, 0));
        idle(4);
        rd(2'd2, v);
        chk("R2 bad size sets cfg error and done", v & 32'h3F00_0000, 32'h2100_0000);
        chk("R2 bad size no access", 32'(acc_cnt - a0), 32'd0);

        // R3 zero count, then misaligned count
        wr(2'd2, 32'h0100_0000);
        wr(2'd2, 32'd0);
        wr(2'd3, mk_ctrl(0, 1, 0, 0, 1, 1, 2'd1, 2'd1, 2'd0, 0));
        idle(4);
        rd(2'd2, v);
        chk("R3 zero count cfg error", v & 32'h3F00_0000, 32'h2100_0000);
        wr(2'd2, 32'h0100_0000);
        wr(2'd2, 32'd6);
        wr(2'd3, mk_ctrl(0, 1, 0, 0, 1, 1, 2'd1, 2'd0, 2'd0, 0));
        idle(4);
        rd(2'd2, v);
        chk("R3 misaligned count cfg error", v, 32'h2100_0006);
        chk("R3 no access", 32'(acc_cnt - a0), 32'd0);

        // R10 irq with enable, R12 clear
        wr(2'd3, mk_ctrl(0, 0, 0, 0, 1, 1, 2'd1, 2'd0, 2'd0, 1));
        idle(1);
        chk("R10 irq high with done and enable", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h0100_0000);
        rd(2'd2, v);
        chk("R12 clear keeps count", v, 32'h0000_0006);
        chk("R10 irq low after clear", {31'd0, irq}, 32'd0);

        // R7 cycle-steal with link mode 1 (R9)
        init_mem();
        wr(2'd0, 32'h00); wr(2'd1, 32'h80); wr(2'd2, 32'd4);
        wr(2'd3, mk_ctrl(1, 0, 1, 0, 1, 1, 2'd1, 2'd1, 2'd1, 0));
        l10 = l1_cnt; l20 = l2_cnt; a0 = acc_cnt;
        pulse_req();
        idle(12);
        rd(2'd2, v);
        chk("R7 one beat per request, busy held", v, 32'h0200_0003);
        chk("R7 one read and one write", 32'(acc_cnt - a0), 32'd2);
        chk("R9 mode 1 link1 after steal beat", 32'(l1_cnt - l10), 32'd1);
        for (int k = 0; k < 3; k++) begin
            pulse_req();
            idle(12);
        end
        rd(2'd2, v);
        chk("R7 done after final request", v, 32'h0100_0000);
        chk("R9 mode 1 link1 total", 32'(l1_cnt - l10), 32'd4);
        chk("R9 mode 1 link2 at end", 32'(l2_cnt - l20), 32'd1);
        chk("R7 memory byte 3", {24'd0, mem[8'h83]}, {24'd0, pat(3)});
        chk("R10 irq low without enable", {31'd0, irq}, 32'd0);

        // R14 pending while request enable clear
        wr(2'd2, 32'h0100_0000);
        wr(2'd2, 32'd2);
        wr(2'd3, mk_ctrl(0, 0, 1, 0, 1, 1, 2'd1, 2'd1, 2'd0, 0));
        a0 = acc_cnt;
        pulse_req();
        idle(8);
        rd(2'd2, v);
        chk("R14 request held pending", v, 32'h0400_0002);
        chk("R14 no access while disabled", 32'(acc_cnt - a0), 32'd0);
        wr(2'd3, mk_ctrl(1, 0, 1, 0, 1, 1, 2'd1, 2'd1, 2'd0, 0));
        idle(12);
        rd(2'd2, v);
        chk("R14 pending served", v, 32'h0200_0001);
        rd(2'd0, v);
        chk("R14 served beat source address", v, 32'h05);

        // R13 pause and resume, link mode 2 continuous
        init_mem();
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
        wr(2'd2, 32'h0100_0000);
        wr(2'd0, 32'h10); wr(2'd1, 32'h90); wr(2'd2, 32'd16);
        wr(2'd3, mk_ctrl(1, 0, 0, 0, 1, 1, 2'd1, 2'd1, 2'd2, 0));
        l10 = l1_cnt;
        pulse_req();
        idle(9);
        wr(2'd3, mk_ctrl(0, 0, 0, 0, 1, 1, 2'd1, 2'd1, 2'd2, 0));
        idle(20);
        rd(2'd2, v);
        idle(10);
        rd(2'd2, v2);
        chk("R13 count frozen while paused", v2, v);
        chk("R13 busy held, not done", v2 & 32'h0300_0000, 32'h0200_0000);
        wr(2'd3, mk_ctrl(1, 0, 0, 0, 1, 1, 2'd1, 2'd1, 2'd2, 0));
        wait_done();
        idle(2);
        rd(2'd0, v);
        chk("R13 resumed to end source address", v, 32'h20);
        rd(2'd1, v);
        chk("R13 resumed to end destination address", v, 32'hA0);
        chk("R9 mode 2 link1 every beat", 32'(l1_cnt - l10), 32'd16);
        chk("R13 last byte copied", {24'd0, mem[8'h9F]}, {24'd0, pat(8'h1F)});

        // R9 mode 3: link1 only at end
        wr(2'd2, 32'h0100_0000);
        wr(2'd0, 32'h00); wr(2'd1, 32'h80); wr(2'd2, 32'd4);
        l10 = l1_cnt; l20 = l2_cnt;
        wr(2'd3, mk_ctrl(0, 1, 0, 0, 1, 1, 2'd1, 2'd1, 2'd3, 0));
        wait_done();
        idle(2);
        chk("R9 mode 3 link1 once", 32'(l1_cnt - l10), 32'd1);
        chk("R9 mode 3 no link2", 32'(l2_cnt - l20), 32'd0);

        // R11 source bus error on third beat
        wr(2'd2, 32'h0100_0000);
        wr(2'd0, 32'h00); wr(2'd1, 32'h80); wr(2'd2, 32'd4);
        err_en = 1'b1; err_addr = 8'h02;
        wr(2'd3, mk_ctrl(0, 1, 0, 0, 1, 1, 2'd1, 2'd1, 2'd0, 1));
        wait_done();
        idle(2);
        rd(2'd2, v);
        chk("R11 source error stops", v, 32'h1100_0002);
        rd(2'd0, v);
        chk("R11 source address at failing beat", v, 32'h02);
        rd(2'd1, v);
        chk("R11 destination address at failing beat", v, 32'h82);
        chk("R10 irq on error done", {31'd0, irq}, 32'd1);

        // R11 destination bus error on fourth beat
        wr(2'd2, 32'h0100_0000);
        wr(2'd0, 32'h00); wr(2'd1, 32'h80); wr(2'd2, 32'd4);
        err_addr = 8'h83;
        wr(2'd3, mk_ctrl(0, 1, 0, 0, 1, 1, 2'd1, 2'd1, 2'd0, 0));
        wait_done();
        idle(2);
        rd(2'd2, v);
        chk("R11 destination error stops", v, 32'h0900_0001);
        rd(2'd0, v);
        chk("R11 source address kept", v, 32'h03);
        err_en = 1'b0;
        wr(2'd2, 32'h0100_0000);
        rd(2'd2, v);
        chk("R12 errors cleared", v, 32'h0000_0001);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule